// File: doc/BRIEF.md
# Programmable Clock Divider with Staged Ratio Reload

This block divides a fast reference clock by a programmable ratio and presents the result as one gated output waveform, `div_out`. Software reaches it through a small memory-mapped port: a control word and a ratio word. The control word holds the output enable, a set of per-clock reload-request flags and one global reload trigger.

A ratio written to the ratio word is held in a staging register and does not change the running division. The staged ratio moves into the active divider only after two things happen. First, this clock's reload-request flag must be 1. Second, the global trigger must rise from 0 to 1 while that flag is 1. The block then waits for the end of the current output period before it switches, so no period is ever clipped or stretched.

Legal ratios are 4, 5, 6 and 8. Any other staged value is forced into that set at the moment it is applied. A reload request made while the output is disabled takes effect at once. The block is used wherever a peripheral clock needs a slow, software-tunable rate that can be changed safely while it runs.

Top module: `clkdiv_reload`

## Requirements
- R1: After synchronous reset, the control word reads 0, the ratio word reads 0, `div_out` is low, and the active ratio is 4.
- R2: The control word is at byte address 0x0, and all 32 of its bits are writable and read back. The ratio word is at byte address `RATIO_ADDR` (0x8 by default, or 0x4). Its ratio field is bits [13:8], and a read of the ratio word returns the last written field with every other bit 0. An unmapped address reads 0. Read data appears on `reg_rdata` one clock after `reg_re` is sampled.
- R3: The output enable is control bit `CLK_IDX + EN_OFS` (bit 25 by default; `EN_OFS` may be 16). While it is 0, `div_out` is low and the divide counter is held at zero.
- R4: Setting the enable starts a fresh period. `div_out` is high in the first cycle after the write edge.
- R5: With active ratio N, `div_out` repeats with a period of N cycles. It is high for floor(N/2) cycles and low for the rest.
- R6: Writing the ratio word on its own leaves the active ratio unchanged.
- R7: A staged ratio is applied only when control bit 8 (the trigger) rises from 0 to 1 while control bit `CLK_IDX` (bit 1, the reload request) is 1. A trigger rise while bit 1 is 0 has no effect.
- R8: While the output is enabled, a pending reload is applied at the end of the current period. Every output period therefore uses either the old ratio or the new ratio, never a mix.
- R9: When applied, a staged value below 4 becomes 4, values 4, 5 and 6 stay as they are, and 7 or any value of 8 or more becomes 8.
- R10: Clearing control bits [8:0] after a reload, either before or after it is applied, does not disturb the active ratio or the pending reload.
- R11: A reload made pending while the output is disabled is applied on the next clock, so the first period after enabling already uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| div_out | output | 1 | Divided, gated output waveform |

## Verification
A control write takes effect at the clock edge that samples it. The output therefore reflects a new enable in the first cycle after that edge, and the bench samples that cycle at the falling edge right after its write. Read data is due one edge after the strobe and is checked at the following falling edge. A reload is asynchronous to the period phase: the request is registered one edge after the trigger rises, and the switch waits for a period end. For that reason the bench does not predict the switch cycle. It synchronises to the next rising edge of `div_out`, requires the first whole period to match either the old ratio or the new one, and requires every period after it to match the new ratio.

// File: rtl/clkdiv_reload.sv
module clkdiv_reload #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int RATIO_ADDR = 8,
  parameter int EN_OFS     = 24,
  parameter int CLK_IDX    = 1,
  parameter int TRIG_BIT   = 8,
  parameter int FIELD_LSB  = 8,
  parameter int FIELD_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              div_out
);

  localparam int EN_BIT = CLK_IDX + EN_OFS;
  localparam int CNT_W  = 4;
  localparam logic [ADDR_W-1:0] CTRL_A = '0;
  localparam logic [ADDR_W-1:0] RAT_A  = ADDR_W'(RATIO_ADDR);

  logic [DATA_W-1:0]  ctrl;
  logic [FIELD_W-1:0] staged;
  logic               trig_q;
  logic               pend;
  logic [CNT_W-1:0]   active;
  logic [CNT_W-1:0]   cnt;

  function automatic logic [CNT_W-1:0] clamp_ratio(input logic [FIELD_W-1:0] v);
    if (v < FIELD_W'(4))      return CNT_W'(4);
    else if (v >= FIELD_W'(7)) return CNT_W'(8);
    else                      return v[CNT_W-1:0];
  endfunction

  wire en     = ctrl[EN_BIT];
  wire at_end = (cnt == active - CNT_W'(1));
  wire req    = ctrl[TRIG_BIT] & ~trig_q & ctrl[CLK_IDX];
  wire apply  = pend & (~en | at_end);

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == CTRL_A)     rd_mux = ctrl;
    else if (reg_addr == RAT_A) rd_mux[FIELD_LSB +: FIELD_W] = staged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      staged    <= '0;
      trig_q    <= 1'b0;
      pend      <= 1'b0;
      active    <= CNT_W'(4);
      cnt       <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_addr == CTRL_A) ctrl   <= reg_wdata;
      if (reg_we && reg_addr == RAT_A)  staged <= reg_wdata[FIELD_LSB +: FIELD_W];
      if (reg_re) reg_rdata <= rd_mux;
      trig_q <= ctrl[TRIG_BIT];
      pend   <= req | (pend & ~apply);
      if (apply) active <= clamp_ratio(staged);
      if (!en || at_end) cnt <= '0;
      else               cnt <= cnt + CNT_W'(1);
    end
  end

  assign div_out = en && (cnt < (active >> 1));

  assert_ratio_legal_R9: assert property (@(posedge clk) disable iff (rst)
    active == 4 || active == 5 || active == 6 || active == 8);

  assert_swap_needs_request_R7: assert property (@(posedge clk) disable iff (rst)
    (active != $past(active)) |-> $past(pend));

  assert_swap_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    (active != $past(active)) |-> ($past(at_end) || !$past(en)));

  assert_off_holds_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (cnt == '0));

  assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (rst)
    cnt < active);

endmodule

// File: tb/tb_clkdiv_reload.sv
module tb_clkdiv_reload;
  localparam int EN = 1 << 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        div_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  clkdiv_reload dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .div_out(div_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic meas(input bit from_now, output int hi, output int per);
    int lo;
    bit prev;
    if (!from_now) begin
      forever begin
        prev = div_out;
        @(negedge clk);
        if (div_out && !prev) break;
      end
    end
    hi = 0; lo = 0;
    while (div_out)  begin hi++; @(negedge clk); end
    while (!div_out) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic reload(input int v);
    wr(4'h8, v << 8);
    wr(4'h0, EN | 32'h2);
    wr(4'h0, EN | 32'h102);
    wr(4'h0, EN);
  endtask

  task automatic expect_steady(input string req, input int n, input int count);
    int hi, per;
    meas(1'b0, hi, per);
    for (int i = 0; i < count; i++) begin
      if (i > 0) meas(1'b1, hi, per);
      chk(req, per, n);
      chk(req, hi, n / 2);
    end
  endtask

  task automatic expect_switch(input string req, input int oldn, input int newn);
    int hi, per;
    meas(1'b0, hi, per);
    vectors++;
    if (!((per == oldn && hi == oldn / 2) || (per == newn && hi == newn / 2))) begin
      errors++;
      $display("FAIL %s: mixed period hi %0d per %0d expected %0d or %0d", req, hi, per, oldn, newn);
    end
    for (int i = 0; i < 3; i++) begin
      meas(1'b1, hi, per);
      chk(req, per, newn);
      chk(req, hi, newn / 2);
    end
  endtask

  task automatic t_reset;
    int d, hi, per;
    chk("R1 out", div_out, 0);
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h8, d); chk("R1 ratio", d, 0);
    wr(4'h0, EN);
    chk("R4 first cycle high", div_out, 1);
    meas(1'b1, hi, per);
    chk("R1 default period", per, 4);
    chk("R5 high of 4", hi, 2);
  endtask

  task automatic t_regs;
    int d;
    wr(4'h0, EN | 32'h5A3C_00F0);
    rd(4'h0, d); chk("R2 ctrl readback", d, EN | 32'h5A3C_00F0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R2 ratio field only", d, 32'h3F00);
    rd(4'h4, d); chk("R2 unmapped", d, 0);
    wr(4'h8, 32'h0000_0500);
    rd(4'h8, d); chk("R2 ratio readback", d, 32'h0500);
    wr(4'h0, EN);
    expect_steady("R6 ratio write alone", 4, 3);
  endtask

  task automatic t_noforce;
    wr(4'h0, EN | 32'h100);
    wr(4'h0, EN);
    expect_steady("R7 trigger without request", 4, 3);
  endtask

  task automatic t_reload;
    reload(5); expect_switch("R8 4 to 5", 4, 5);
    reload(6); expect_switch("R8 5 to 6", 5, 6);
    reload(8); expect_switch("R5 6 to 8", 6, 8);
    expect_steady("R10 bits cleared", 8, 2);
    reload(4); expect_switch("R8 8 to 4", 8, 4);
  endtask

  task automatic t_clamp;
    int d;
    reload(2);  expect_switch("R9 2 to 4", 4, 4);
    reload(7);  expect_switch("R9 7 to 8", 4, 8);
    rd(4'h8, d); chk("R2 raw 7 readback", d, 32'h0700);
    reload(3);  expect_switch("R9 3 to 4", 8, 4);
    reload(63); expect_switch("R9 63 to 8", 4, 8);
    reload(8);  expect_steady("R9 8 stays", 8, 2);
  endtask

  task automatic t_disable;
    int hi, per, lows;
    repeat (3) @(negedge clk);
    wr(4'h0, 0);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      if (!div_out) lows++;
      @(negedge clk);
    end
    chk("R3 held low", lows, 20);
    wr(4'h0, EN);
    chk("R4 restart high", div_out, 1);
    meas(1'b1, hi, per);
    chk("R4 fresh period", per, 8);
    chk("R4 fresh high", hi, 4);
  endtask

  task automatic t_disabled_apply;
    int hi, per;
    wr(4'h0, 0);
    wr(4'h8, 5 << 8);
    wr(4'h0, 32'h2);
    wr(4'h0, 32'h102);
    wr(4'h0, 0);
    repeat (3) @(negedge clk);
    wr(4'h0, EN);
    meas(1'b1, hi, per);
    chk("R11 first period", per, 5);
    chk("R11 first high", hi, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_regs;
    t_noforce;
    t_reload;
    t_clamp;
    t_disable;
    t_disabled_apply;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule